// File: doc/BRIEF.md
# PLL-Based FSK Demodulator

This block turns a stream of signed 8-bit audio samples into a received data bit for a two-tone, two-channel modem. For each accepted sample it runs three cascaded second-order integer bandpass sections tuned to the selected receive channel. It reduces the filtered signal to its sign and feeds that bit into a digital phase-locked loop. The loop is a 16-bit phase accumulator with a fixed centre step, an XOR phase detector and a one-pole low-pass loop filter. The tone frequency shows up in the loop's control word. A second one-pole stage smooths that word, and comparing it against a threshold gives the data bit.

A sample-valid strobe drives every update, so the block can run from a fast system clock while samples arrive at audio rate. A one-bit channel select picks the bandpass coefficients and the oscillator centre step. Changing it clears all filter and loop history, so no sample is ever processed with a mix of the two coefficient sets.

Top module: `fsk_pll_demod`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `data_o` is 0 and all filter, oscillator and loop state is zero.
- R2: Each bandpass stage computes y0 = (g*(x0 - x2) + a*y1 - 4*y2) >>> 3 using arithmetic shift. The gains g are 8, 3 and 2 for the first, second and third stage. The input of each stage is the new output of the stage before it, and the first stage takes the sample. The coefficient a is +7 when `mode_i` = 0 (low channel) and -1 when `mode_i` = 1 (high channel).
- R3: The datapath is 24 bits wide, two's complement. For any 8-bit input sequence, including full-scale square waves between -128 and +127, no bandpass output leaves the signed range of ±2^22.
- R4: The sliced bit is 1 when the third stage output is greater than or equal to zero, and 0 otherwise.
- R5: On each accepted sample, the 16-bit phase accumulator adds the centre step plus the previous loop-filter value, modulo 2^16. The step is 7882 for `mode_i` = 0 and 15643 for `mode_i` = 1. Bit 15 of the new accumulator value is the oscillator bit.
- R6: The phase detector gives 0 when the sliced bit equals the oscillator bit and 3000 when they differ.
- R7: The loop filter updates as LP = PD + ((7*(LP - PD)) >>> 3), and LP stays within 0 to 3000.
- R8: The output filter updates as OP = OP + ((LP_new - OP) >>> 3). The new `data_o` is 1 when the new OP is at least 1500, and OP stays within 0 to 3000.
- R9: State and `data_o` change only on a clock edge where `valid_i` is high. `data_o` is registered and reflects the sample accepted at that edge.
- R10: On any clock edge where `mode_i` differs from its value at the previous edge, all filter, oscillator and loop state is cleared. No sample is accepted at that edge and `data_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample-valid strobe, one clock per sample |
| sample_i | input | 8 | Signed audio sample |
| mode_i | input | 1 | Receive channel: 0 low, 1 high |
| data_o | output | 1 | Registered recovered data bit |

## Verification
A wrong coefficient, gain or shift anywhere in the chain changes the sliced bit or the control word. That change reaches `data_o` one strobe later at the earliest, and usually within a few tens of samples while the output filter integrates the error. The bench compares `data_o` against an independent model after every strobe, through tone bursts in both channels, full-scale square waves and silence, so divergence is caught on the first sample it appears. A missing clear on channel change, or an update without a strobe, leaves stale history. That history pushes later outputs off the model, so the bench follows each such event with a run of compared samples.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic {
    CH_LOW  = 1'b0,
    CH_HIGH = 1'b1
  } chan_e;

  localparam int N_STAGE = 3;

  function automatic int stage_gain(input int idx);
    case (idx)
      0:       return 8;
      1:       return 3;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/fsk_bp_stage.sv
module fsk_bp_stage #(
  parameter int W = 24,
  parameter int G = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  fsk_pkg::chan_e      chan_i,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] y_o
);
  localparam int AW = W + 4;

  logic signed [W-1:0]  x1_q, x2_q, y1_q, y2_q;
  logic signed [AW-1:0] xe, x2e, y1e, y2e, fb, acc;

  assign xe  = AW'(x_i);
  assign x2e = AW'(x2_q);
  assign y1e = AW'(y1_q);
  assign y2e = AW'(y2_q);

  // a = +7 low channel, -1 high channel
  assign fb  = (chan_i == fsk_pkg::CH_HIGH) ? -y1e : ((y1e <<< 3) - y1e);
  assign acc = AW'(G) * (xe - x2e) + fb - (y2e <<< 2);
  assign y_o = W'(acc >>> 3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (clr_i) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (en_i) begin
      x2_q <= x1_q;
      x1_q <= x_i;
      y2_q <= y1_q;
      y1_q <= y_o;
    end
  end
endmodule

// File: rtl/fsk_dpll.sv
module fsk_dpll #(
  parameter int W        = 24,
  parameter int PHASE_W  = 16,
  parameter int STEP_LO  = 7882,
  parameter int STEP_HI  = 15643,
  parameter int PD_GAIN  = 3000,
  parameter int THRESH   = PD_GAIN / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  fsk_pkg::chan_e      chan_i,
  input  logic                sx_i,
  output logic [PHASE_W-1:0]  pa_o,
  output logic signed [W-1:0] lp_o,
  output logic signed [W-1:0] op_o,
  output logic                data_o
);
  logic [PHASE_W-1:0]  pa_q, pa_d, step;
  logic signed [W-1:0] lp_q, lp_d, op_q, op_d, pd, lp_diff, lp_mul;
  logic                data_q, data_d, osc_bit;

  assign step    = (chan_i == fsk_pkg::CH_HIGH) ? PHASE_W'(STEP_HI) : PHASE_W'(STEP_LO);
  assign pa_d    = pa_q + step + PHASE_W'(lp_q);
  assign osc_bit = pa_d[PHASE_W-1];

  // XOR detector
  assign pd      = (sx_i != osc_bit) ? W'(PD_GAIN) : '0;

  // one-pole loop filter, pole 7/8
  assign lp_diff = lp_q - pd;
  assign lp_mul  = (lp_diff <<< 3) - lp_diff;
  assign lp_d    = pd + (lp_mul >>> 3);

  assign op_d    = op_q + ((lp_d - op_q) >>> 3);
  assign data_d  = (op_d >= W'(THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0;
      lp_q <= '0;
      op_q <= '0;
    end else if (clr_i) begin
      pa_q <= '0;
      lp_q <= '0;
      op_q <= '0;
    end else if (en_i) begin
      pa_q <= pa_d;
      lp_q <= lp_d;
      op_q <= op_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= 1'b0;
    else if (en_i) data_q <= data_d;
  end

  assign pa_o   = pa_q;
  assign lp_o   = lp_q;
  assign op_o   = op_q;
  assign data_o = data_q;
endmodule

// File: rtl/fsk_pll_demod.sv
module fsk_pll_demod #(
  parameter int W        = 24,
  parameter int SAMPLE_W = 8,
  parameter int PHASE_W  = 16,
  parameter int STEP_LO  = 7882,
  parameter int STEP_HI  = 15643,
  parameter int PD_GAIN  = 3000,
  parameter int THRESH   = PD_GAIN / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                mode_i,
  output logic                data_o
);
  localparam int NS = fsk_pkg::N_STAGE;

  fsk_pkg::chan_e             chan_q, chan_in;
  logic                       clr, en, sx;
  logic [NS-1:0][W-1:0]       bp_y;
  logic signed [W-1:0]        samp_ext;
  logic [PHASE_W-1:0]         pa_w;
  logic signed [W-1:0]        lp_w, op_w;

  assign chan_in  = fsk_pkg::chan_e'(mode_i);
  assign clr      = (chan_in != chan_q);
  assign en       = valid_i && !clr;
  assign samp_ext = W'($signed(sample_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= fsk_pkg::CH_LOW;
    else         chan_q <= chan_in;
  end

  for (genvar k = 0; k < NS; k++) begin : g_stage
    logic signed [W-1:0] x_in, y_out;
    if (k == 0) begin : g_first
      assign x_in = samp_ext;
    end else begin : g_next
      assign x_in = $signed(bp_y[k-1]);
    end
    fsk_bp_stage #(
      .W (W),
      .G (fsk_pkg::stage_gain(k))
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .clr_i  (clr),
      .chan_i (chan_q),
      .x_i    (x_in),
      .y_o    (y_out)
    );
    assign bp_y[k] = y_out;
  end

  assign sx = ~bp_y[NS-1][W-1];

  fsk_dpll #(
    .W       (W),
    .PHASE_W (PHASE_W),
    .STEP_LO (STEP_LO),
    .STEP_HI (STEP_HI),
    .PD_GAIN (PD_GAIN),
    .THRESH  (THRESH)
  ) u_dpll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .clr_i  (clr),
    .chan_i (chan_q),
    .sx_i   (sx),
    .pa_o   (pa_w),
    .lp_o   (lp_w),
    .op_o   (op_w),
    .data_o (data_o)
  );
endmodule

// File: rtl/fsk_pll_demod_chk.sv
module fsk_pll_demod_chk #(
  parameter int W       = 24,
  parameter int PHASE_W = 16,
  parameter int NS      = 3,
  parameter int PD_GAIN = 3000
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 mode_i,
  input logic                 data_o,
  input fsk_pkg::chan_e       chan_q,
  input logic [NS-1:0][W-1:0] bp_y,
  input logic [PHASE_W-1:0]   pa_w,
  input logic signed [W-1:0]  lp_w,
  input logic signed [W-1:0]  op_w
);
  localparam logic signed [W-1:0] LIM = W'(1) <<< (W - 2);

  for (genvar k = 0; k < NS; k++) begin : g_ovf
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($signed(bp_y[k]) < LIM) && ($signed(bp_y[k]) > -LIM)); // R3
  end

  AST_LP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_w >= 0) && (lp_w <= W'(PD_GAIN))); // R7

  AST_OP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_w >= 0) && (op_w <= W'(PD_GAIN))); // R8

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)); // R9

  AST_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsk_pkg::chan_e'(mode_i) != chan_q) |=> (pa_w == '0 && lp_w == '0 && op_w == '0)); // R10

  AST_MODE_KEEP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsk_pkg::chan_e'(mode_i) != chan_q) |=> $stable(data_o)); // R10

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_DATA: assert (data_o == 1'b0); // R1
  end
endmodule

bind fsk_pll_demod fsk_pll_demod_chk #(
  .W       (W),
  .PHASE_W (PHASE_W),
  .NS      (fsk_pkg::N_STAGE),
  .PD_GAIN (PD_GAIN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .data_o  (data_o),
  .chan_q  (chan_q),
  .bp_y    (bp_y),
  .pa_w    (pa_w),
  .lp_w    (lp_w),
  .op_w    (op_w)
);

// File: tb/fsk_pll_demod_tb.sv
module fsk_pll_demod_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic       mode_i = 1'b0;
  logic       data_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  fsk_pll_demod u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sample_i (sample_i),
    .mode_i   (mode_i),
    .data_o   (data_o)
  );

  // scenario: {mode, kind(0 sine,1 square,2 zero), tone step, count}
  localparam logic [34:0] SCN [0:9] = '{
    {1'b0, 2'd0, 16'd8694,  16'd400},
    {1'b0, 2'd0, 16'd10320, 16'd400},
    {1'b0, 2'd0, 16'd8694,  16'd300},
    {1'b0, 2'd2, 16'd0,     16'd50},
    {1'b0, 2'd1, 16'd9000,  16'd200},
    {1'b1, 2'd0, 16'd16455, 16'd400},
    {1'b1, 2'd0, 16'd18080, 16'd400},
    {1'b1, 2'd1, 16'd17000, 16'd200},
    {1'b1, 2'd0, 16'd16455, 16'd300},
    {1'b0, 2'd0, 16'd10320, 16'd300}
  };

  // reference model state
  longint m_x1 [3], m_x2 [3], m_y1 [3], m_y2 [3];
  longint m_pa, m_lp, m_op;
  bit     m_data;
  bit     m_mode;
  int     tphase;

  function automatic longint sra3(input longint v);
    return v >>> 3;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 3; s++) begin
      m_x1[s] = 0; m_x2[s] = 0; m_y1[s] = 0; m_y2[s] = 0;
    end
    m_pa = 0; m_lp = 0; m_op = 0;
  endtask

  task automatic model_step(input int smp);
    longint x, y, g, a, pd;
    bit sx, px;
    x = smp;
    a = m_mode ? -1 : 7;
    for (int s = 0; s < 3; s++) begin
      g = (s == 0) ? 8 : (s == 1) ? 3 : 2;
      y = sra3(g * (x - m_x2[s]) + a * m_y1[s] - 4 * m_y2[s]);
      m_x2[s] = m_x1[s]; m_x1[s] = x;
      m_y2[s] = m_y1[s]; m_y1[s] = y;
      x = y;
    end
    sx = (x >= 0);
    m_pa = (m_pa + (m_mode ? 15643 : 7882) + m_lp) & 65535;
    px = m_pa[15];
    pd = (sx != px) ? 3000 : 0;
    m_lp = pd + sra3(7 * (m_lp - pd));
    m_op = m_op + sra3(m_lp - m_op);
    m_data = (m_op >= 1500);
  endtask

  task automatic check(input string tag, input bit exp);
    total++;
    if (data_o !== exp) begin
      bad++;
      $display("FAIL %s data_o act=%0b exp=%0b", tag, data_o, exp);
    end
  endtask

  task automatic send(input int smp, input string tag);
    @(negedge clk_i);
    valid_i  = 1'b1;
    sample_i = 8'(smp);
    @(negedge clk_i);
    valid_i  = 1'b0;
    model_step(smp);
    check(tag, m_data);
  endtask

  task automatic switch_mode(input bit m);
    @(negedge clk_i);
    mode_i = m;
    @(negedge clk_i);
    m_mode = m;
    model_clear();
    check("R10 data held on mode change", m_data);
  endtask

  function automatic int gen(input int kind, input int step);
    int v;
    real ph;
    tphase = (tphase + step) & 65535;
    ph = 6.283185307179586 * tphase / 65536.0;
    case (kind)
      0:       v = $rtoi($floor(127.0 * $sin(ph) + 0.5));
      1:       v = (tphase >= 32768) ? 127 : -128;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_mode = 0; m_data = 0; tphase = 0;
    model_clear();
    repeat (3) @(negedge clk_i);
    check("R1 data_o low in reset", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 data_o low after reset", 1'b0);

    for (int i = 0; i < 10; i++) begin
      bit m;
      int kind, step, cnt;
      m    = SCN[i][34];
      kind = int'(SCN[i][33:32]);
      step = int'(SCN[i][31:16]);
      cnt  = int'(SCN[i][15:0]);
      if (m != m_mode) switch_mode(m);
      for (int n = 0; n < cnt; n++) begin
        int smp;
        smp = gen(kind, step);
        if (kind == 1) send(smp, "R3 full-scale square");
        else if (m)    send(smp, "R2 R4 R5 R6 R7 R8 high channel");
        else           send(smp, "R2 R4 R5 R6 R7 R8 low channel");
      end
    end

    // R9: no strobe, sample wiggles, nothing may move
    for (int n = 0; n < 20; n++) begin
      @(negedge clk_i);
      sample_i = (n % 2 == 0) ? 8'h7f : 8'h80;
      check("R9 hold without strobe", m_data);
    end
    for (int n = 0; n < 100; n++) send(gen(0, 8694), "R9 state untouched");

    // R10: back-to-back channel changes, then resume
    switch_mode(1'b1);
    switch_mode(1'b0);
    for (int n = 0; n < 150; n++) send(gen(0, 10320), "R10 clean restart");

    // R1: async reset mid-stream
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset clears data_o", 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_mode = mode_i;
    m_data = 0;
    model_clear();
    for (int n = 0; n < 150; n++) send(gen(0, 8694), "R1 fresh state after reset");

    summary();
  end
endmodule